// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the write side of one eight-input interrupt controller. Software reaches it through two byte-wide write strobes sharing one data bus: a command strobe and a data strobe. A command byte with bit 4 set starts (or restarts) initialization. The data bytes that follow are steered by the sequencer state into the vector base, the cascade word and the mode word. Once the sequence is complete, data bytes load the interrupt mask. Command bytes are then decoded as operational commands: end-of-interrupt variants, priority and no-op commands, and a read-control word that is simply stored.

The block owns the eight-bit in-service register. Priority logic elsewhere sets bits through a one-hot `isr_set` input, and this block clears them on end-of-interrupt. Each cleared line is reported on a one-cycle strobe together with its index, so a wrapper that cascades two controllers can drop the linked request on the primary. A separate strobe writes the edge/level register, and only the bits of a fixed writable mask can be written. All outputs are registered and change on the clock edge that captures the write.

Top module: `irq_cmd_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released: `seq_state` is 0 (idle), every stored word, `irq_mask`, `in_service` and `trig_mode` are zero, and `cmd_err` and `eoi_valid` are low.
- R2: A command write with bit 4 set stores the byte in `init_word` and moves `seq_state` to 1 (expect vector base), from any state. `init_word` changes on no other write.
- R3: In state 1, a data write stores `vec_base`. The next state is 2 (expect cascade) if `init_word` bit 1 is 0. If bit 1 is 1, the next state is 3 (expect mode) when bit 0 is 1, and 4 (ready) when bit 0 is 0.
- R4: In state 2, a data write stores `casc_word`. The next state is 3 when `init_word` bit 0 is 1, and 4 otherwise.
- R5: In state 3, a data write stores `mode_word` and moves the state to 4.
- R6: In state 0 or state 4, a data write loads `irq_mask` and leaves the state unchanged.
- R7: A command write with bit 4 clear, made in any state other than 4, pulses `cmd_err` for one cycle and changes no state or register.
- R8: In state 4, the command byte `011_00_LLL` (bit 7 R=0, bit 6 SL=1, bit 5 EOI=1, bits 2:0 the level) clears `in_service[LLL]`. It also pulses `eoi_valid` with `eoi_index` = LLL.
- R9: In state 4, the command byte `001_00_xxx` clears the lowest-numbered set bit of `in_service` and pulses `eoi_valid` with that bit's index. If no bit is set, nothing changes and no pulse is made.
- R10: In state 4, OCW2 bytes (bits 4:3 = 00) with R=1 and SL=1, and bytes with EOI=0, R=0, SL=1, are accepted without effect. The remaining combinations (bits 7:5 = 000, 100 or 101) pulse `cmd_err`.
- R11: In state 4, a command byte with bit 4 = 0 and bit 3 = 1 is stored in `ocw3_word` without error.
- R12: A `trig_we` write stores `wr_data & TRIG_WRMASK` in `trig_mode`. The default writable mask is 8'hF8.
- R13: Bits set in `isr_set` are set in `in_service` on the next edge. If an end-of-interrupt clears the same bit in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command-port write strobe (has priority over data_we) |
| data_we | input | 1 | Data-port write strobe |
| trig_we | input | 1 | Edge/level register write strobe |
| wr_data | input | W | Write data shared by all strobes |
| isr_set | input | LINES | One-hot in-service set request from priority logic |
| seq_state | output | 3 | Sequencer state: 0 idle, 1 vector base, 2 cascade, 3 mode, 4 ready |
| init_word | output | W | Stored initialization command |
| vec_base | output | W | Stored vector base |
| casc_word | output | W | Stored cascade word |
| mode_word | output | W | Stored mode word |
| ocw3_word | output | W | Stored read-control command |
| irq_mask | output | LINES | Interrupt mask register |
| in_service | output | LINES | In-service register |
| trig_mode | output | LINES | Edge/level register |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| eoi_valid | output | 1 | One-cycle pulse when an end-of-interrupt clears a line |
| eoi_index | output | IDX_W | Index of the line cleared by the end-of-interrupt |

## Verification
Every result is registered one level deep. A write presented before a rising edge is reflected on the outputs immediately after that edge, and the `cmd_err` and `eoi_valid` pulses last exactly that one cycle. The bench drives each strobe from one falling edge to the next and samples all outputs at that second falling edge. A one-cycle pulse is therefore seen at its only valid point, and the stored words are seen once they have settled. Words that should not move are read back after later writes to show they were untouched.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_VBASE = 3'd1,
    SEQ_CASC  = 3'd2,
    SEQ_MODE  = 3'd3,
    SEQ_READY = 3'd4
  } seq_t;

  localparam int START_BIT  = 4;
  localparam int OCW_SEL    = 3;
  localparam int SINGLE_BIT = 1;
  localparam int NEEDM_BIT  = 0;
  localparam int R_BIT      = 7;
  localparam int SL_BIT     = 6;
  localparam int EOI_BIT    = 5;
endpackage

// File: rtl/irq_cmd_fsm.sv
module irq_cmd_fsm
  import irq_cmd_pkg::*;
#(
  parameter int W = 8,
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             data_we,
  input  logic [W-1:0]     wr_data,
  output seq_t             state,
  output logic [W-1:0]     init_word,
  output logic [W-1:0]     vec_base,
  output logic [W-1:0]     casc_word,
  output logic [W-1:0]     mode_word,
  output logic [W-1:0]     ocw3_word,
  output logic [LINES-1:0] mask,
  output logic             cmd_err,
  output logic             eoi_spec,
  output logic             eoi_low
);
  logic is_start, is_op2, op2_ok;
  logic r_b, sl_b, eoi_b;
  seq_t after_base, after_casc;

  assign is_start = wr_data[START_BIT];
  assign r_b   = wr_data[R_BIT];
  assign sl_b  = wr_data[SL_BIT];
  assign eoi_b = wr_data[EOI_BIT];
  assign is_op2 = cmd_we && !is_start && !wr_data[OCW_SEL] && (state == SEQ_READY);
  assign op2_ok = (eoi_b && !r_b) || (r_b && sl_b) || (!eoi_b && !r_b && sl_b);
  assign eoi_spec = is_op2 && eoi_b && !r_b && sl_b;
  assign eoi_low  = is_op2 && eoi_b && !r_b && !sl_b;

  always_comb begin
    after_casc = init_word[NEEDM_BIT] ? SEQ_MODE : SEQ_READY;
    after_base = init_word[SINGLE_BIT] ? after_casc : SEQ_CASC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      init_word <= '0;
      vec_base  <= '0;
      casc_word <= '0;
      mode_word <= '0;
      ocw3_word <= '0;
      mask      <= '0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (cmd_we) begin
        if (is_start) begin
          init_word <= wr_data;
          state     <= SEQ_VBASE;
        end else if (state != SEQ_READY) begin
          cmd_err <= 1'b1;
        end else if (wr_data[OCW_SEL]) begin
          ocw3_word <= wr_data;
        end else if (!op2_ok) begin
          cmd_err <= 1'b1;
        end
      end else if (data_we) begin
        case (state)
          SEQ_VBASE: begin
            vec_base <= wr_data;
            state    <= after_base;
          end
          SEQ_CASC: begin
            casc_word <= wr_data;
            state     <= after_casc;
          end
          SEQ_MODE: begin
            mode_word <= wr_data;
            state     <= SEQ_READY;
          end
          default: mask <= wr_data[LINES-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_isr_unit.sv
module irq_isr_unit #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] isr_set,
  input  logic             eoi_spec,
  input  logic             eoi_low,
  input  logic [IDX_W-1:0] level,
  output logic [LINES-1:0] isr,
  output logic             eoi_valid,
  output logic [IDX_W-1:0] eoi_index
);
  logic             low_hit;
  logic [IDX_W-1:0] low_idx;
  logic [LINES-1:0] clr;

  always_comb begin
    low_hit = 1'b0;
    low_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isr[i]) begin
        low_hit = 1'b1;
        low_idx = IDX_W'(i);
      end
    end
    clr = '0;
    if (eoi_spec) clr[level] = 1'b1;
    else if (eoi_low && low_hit) clr[low_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr       <= '0;
      eoi_valid <= 1'b0;
      eoi_index <= '0;
    end else begin
      isr       <= (isr | isr_set) & ~clr;
      eoi_valid <= eoi_spec || (eoi_low && low_hit);
      eoi_index <= eoi_spec ? level : low_idx;
    end
  end
endmodule

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] WRMASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= d & WRMASK;
  end
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_cmd_pkg::*;
#(
  parameter int W = 8,
  parameter int LINES = 8,
  parameter logic [LINES-1:0] TRIG_WRMASK = 8'hF8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             data_we,
  input  logic             trig_we,
  input  logic [W-1:0]     wr_data,
  input  logic [LINES-1:0] isr_set,
  output logic [2:0]       seq_state,
  output logic [W-1:0]     init_word,
  output logic [W-1:0]     vec_base,
  output logic [W-1:0]     casc_word,
  output logic [W-1:0]     mode_word,
  output logic [W-1:0]     ocw3_word,
  output logic [LINES-1:0] irq_mask,
  output logic [LINES-1:0] in_service,
  output logic [LINES-1:0] trig_mode,
  output logic             cmd_err,
  output logic             eoi_valid,
  output logic [IDX_W-1:0] eoi_index
);
  seq_t st;
  logic spec, low;

  irq_cmd_fsm #(.W(W), .LINES(LINES)) u_fsm (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .data_we(data_we), .wr_data(wr_data),
    .state(st), .init_word(init_word), .vec_base(vec_base), .casc_word(casc_word),
    .mode_word(mode_word), .ocw3_word(ocw3_word), .mask(irq_mask),
    .cmd_err(cmd_err), .eoi_spec(spec), .eoi_low(low)
  );

  irq_isr_unit #(.LINES(LINES)) u_isr (
    .clk(clk), .rst(rst), .isr_set(isr_set), .eoi_spec(spec), .eoi_low(low),
    .level(wr_data[IDX_W-1:0]), .isr(in_service), .eoi_valid(eoi_valid),
    .eoi_index(eoi_index)
  );

  irq_trig_reg #(.LINES(LINES), .WRMASK(TRIG_WRMASK)) u_trig (
    .clk(clk), .rst(rst), .we(trig_we), .d(wr_data[LINES-1:0]), .q(trig_mode)
  );

  assign seq_state = st;
endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk #(
  parameter int W = 8,
  parameter int LINES = 8,
  parameter logic [LINES-1:0] TRIG_WRMASK = 8'hF8,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_we,
  input logic             data_we,
  input logic             trig_we,
  input logic [W-1:0]     wr_data,
  input logic [2:0]       seq_state,
  input logic [W-1:0]     init_word,
  input logic [W-1:0]     vec_base,
  input logic [W-1:0]     casc_word,
  input logic [W-1:0]     mode_word,
  input logic [W-1:0]     ocw3_word,
  input logic [LINES-1:0] irq_mask,
  input logic [LINES-1:0] in_service,
  input logic [LINES-1:0] trig_mode,
  input logic             cmd_err,
  input logic             eoi_valid,
  input logic [IDX_W-1:0] eoi_index
);
  assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_we && wr_data[4] |=> seq_state == 3'd1 && init_word == $past(wr_data));
  assert_init_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_we && wr_data[4]) |=> $stable(init_word));
  assert_vbase_R3: assert property (@(posedge clk) disable iff (rst)
    data_we && !cmd_we && seq_state == 3'd1 |=> vec_base == $past(wr_data));
  assert_casc_R4: assert property (@(posedge clk) disable iff (rst)
    data_we && !cmd_we && seq_state == 3'd2 |=> casc_word == $past(wr_data));
  assert_mode_R5: assert property (@(posedge clk) disable iff (rst)
    data_we && !cmd_we && seq_state == 3'd3 |=> seq_state == 3'd4 && mode_word == $past(wr_data));
  assert_mask_R6: assert property (@(posedge clk) disable iff (rst)
    data_we && !cmd_we && (seq_state == 3'd0 || seq_state == 3'd4)
    |=> irq_mask == $past(wr_data[LINES-1:0]));
  assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_we && !wr_data[4] && seq_state != 3'd4 |=> cmd_err && $stable(seq_state));
  assert_err_eoi_excl_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> !eoi_valid);
  assert_spec_eoi_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_we && wr_data[7:3] == 5'b01100 && seq_state == 3'd4
    |=> eoi_valid && eoi_index == $past(wr_data[IDX_W-1:0]) && !in_service[eoi_index]);
  assert_ocw3_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_we && wr_data[4:3] == 2'b01 && seq_state == 3'd4 |=> ocw3_word == $past(wr_data) && !cmd_err);
  assert_trig_R12: assert property (@(posedge clk) disable iff (rst)
    trig_we |=> trig_mode == ($past(wr_data[LINES-1:0]) & TRIG_WRMASK));
endmodule

bind irq_cmd_seq irq_cmd_seq_chk #(.W(W), .LINES(LINES), .TRIG_WRMASK(TRIG_WRMASK)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .data_we(data_we), .trig_we(trig_we),
  .wr_data(wr_data), .seq_state(seq_state), .init_word(init_word), .vec_base(vec_base),
  .casc_word(casc_word), .mode_word(mode_word), .ocw3_word(ocw3_word),
  .irq_mask(irq_mask), .in_service(in_service), .trig_mode(trig_mode),
  .cmd_err(cmd_err), .eoi_valid(eoi_valid), .eoi_index(eoi_index)
);

// File: tb/sim_irq_cmd_seq.sv
module sim_irq_cmd_seq;
  localparam int PERIOD = 10;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0, data_we = 1'b0, trig_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] isr_set = '0;
  logic [2:0] seq_state;
  logic [7:0] init_word, vec_base, casc_word, mode_word, ocw3_word;
  logic [7:0] irq_mask, in_service, trig_mode;
  logic       cmd_err, eoi_valid;
  logic [2:0] eoi_index;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_cmd_seq u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .data_we(data_we), .trig_we(trig_we),
    .wr_data(wr_data), .isr_set(isr_set), .seq_state(seq_state), .init_word(init_word),
    .vec_base(vec_base), .casc_word(casc_word), .mode_word(mode_word),
    .ocw3_word(ocw3_word), .irq_mask(irq_mask), .in_service(in_service),
    .trig_mode(trig_mode), .cmd_err(cmd_err), .eoi_valid(eoi_valid), .eoi_index(eoi_index)
  );

  // entry: {req[3:0], is_data, byte[7:0], exp_state[2:0], exp_err}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd2,  1'b0, 8'h11, 3'd1, 1'b0},  // R2 start, cascade + mode expected
    {4'd3,  1'b1, 8'h20, 3'd2, 1'b0},  // R3 base -> cascade
    {4'd4,  1'b1, 8'h04, 3'd3, 1'b0},  // R4 cascade -> mode
    {4'd5,  1'b1, 8'h01, 3'd4, 1'b0},  // R5 mode -> ready
    {4'd6,  1'b1, 8'hA5, 3'd4, 1'b0},  // R6 mask in ready
    {4'd11, 1'b0, 8'h0A, 3'd4, 1'b0},  // R11 read-control word
    {4'd10, 1'b0, 8'h40, 3'd4, 1'b0},  // R10 no-op
    {4'd10, 1'b0, 8'h00, 3'd4, 1'b1},  // R10 illegal combination
    {4'd2,  1'b0, 8'h13, 3'd1, 1'b0},  // R2 single + mode
    {4'd3,  1'b1, 8'h30, 3'd3, 1'b0},  // R3 skip cascade
    {4'd7,  1'b0, 8'h60, 3'd3, 1'b1},  // R7 operational command too early
    {4'd5,  1'b1, 8'h03, 3'd4, 1'b0},  // R5 mode -> ready
    {4'd2,  1'b0, 8'h1A, 3'd1, 1'b0},  // R2 single, no mode
    {4'd3,  1'b1, 8'h48, 3'd4, 1'b0}   // R3 straight to ready
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic is_cmd, input logic is_data, input logic is_trig,
                    input logic [7:0] d);
    @(negedge clk);
    cmd_we = is_cmd; data_we = is_data; trig_we = is_trig; wr_data = d;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0; trig_we = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 words", {init_word, vec_base, casc_word, mode_word}, 0);
    chk("R1 regs", {ocw3_word, irq_mask, in_service, trig_mode}, 0);
    chk("R1 pulses", {cmd_err, eoi_valid}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] e;
      e = VEC[i];
      wr(!e[12], e[12], 1'b0, e[11:4]);
      chk($sformatf("R%0d vec%0d state", e[16:13], i), seq_state, e[3:1]);
      chk($sformatf("R%0d vec%0d err", e[16:13], i), cmd_err, e[0]);
    end
    chk("R2 init word", init_word, 8'h1A);
    chk("R3 vector base", vec_base, 8'h48);
    chk("R4 cascade word kept", casc_word, 8'h04);
    chk("R5 mode word", mode_word, 8'h03);
    chk("R6 mask kept", irq_mask, 8'hA5);
    chk("R11 ocw3", ocw3_word, 8'h0A);

    // R13 set in-service bits
    @(negedge clk); isr_set = 8'h96;
    @(negedge clk); isr_set = 8'h00;
    chk("R13 isr set", in_service, 8'h96);

    // R9 lowest-first clear
    wr(1'b1, 1'b0, 1'b0, 8'h20);
    chk("R9 isr", in_service, 8'h94);
    chk("R9 pulse", {eoi_valid, eoi_index}, {1'b1, 3'd1});

    // R8 specific clear of line 7
    wr(1'b1, 1'b0, 1'b0, 8'h67);
    chk("R8 isr", in_service, 8'h14);
    chk("R8 pulse", {eoi_valid, eoi_index}, {1'b1, 3'd7});

    // R10 set-priority has no effect
    wr(1'b1, 1'b0, 1'b0, 8'hC3);
    chk("R10 prio isr", in_service, 8'h14);
    chk("R10 prio pulses", {cmd_err, eoi_valid}, 0);
    wr(1'b1, 1'b0, 1'b0, 8'h80);
    chk("R10 bad err", cmd_err, 1);
    chk("R10 bad isr", in_service, 8'h14);

    // R8 specific on line 2, then R9 drains and the empty case
    wr(1'b1, 1'b0, 1'b0, 8'h62);
    chk("R8 line2 isr", in_service, 8'h10);
    chk("R8 line2 idx", eoi_index, 2);
    wr(1'b1, 1'b0, 1'b0, 8'h20);
    chk("R9 last isr", in_service, 8'h00);
    chk("R9 last idx", eoi_index, 4);
    wr(1'b1, 1'b0, 1'b0, 8'h20);
    chk("R9 empty pulse", eoi_valid, 0);
    chk("R9 empty isr", in_service, 8'h00);

    // R13 clear wins over set on the same line
    @(negedge clk); isr_set = 8'h01; cmd_we = 1'b1; wr_data = 8'h60;
    @(negedge clk); isr_set = 8'h00; cmd_we = 1'b0;
    chk("R13 clear wins", in_service, 8'h00);

    // R12 writable-bit filter
    wr(1'b0, 1'b0, 1'b1, 8'hFF);
    chk("R12 trig ff", trig_mode, 8'hF8);
    wr(1'b0, 1'b0, 1'b1, 8'h27);
    chk("R12 trig 27", trig_mode, 8'h20);

    // R2 restart mid-sequence
    wr(1'b1, 1'b0, 1'b0, 8'h11);
    wr(1'b1, 1'b0, 1'b0, 8'h13);
    chk("R2 restart state", seq_state, 1);
    chk("R2 restart word", init_word, 8'h13);

    // R6 mask load in idle after reset; R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rerst state", seq_state, 0);
    chk("R1 rerst trig", trig_mode, 0);
    wr(1'b0, 1'b1, 1'b0, 8'h5C);
    chk("R6 idle mask", irq_mask, 8'h5C);
    chk("R6 idle state", seq_state, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule